// File: doc/BRIEF.md
# Serial Device Identifier Register

This block holds a fixed 57-bit device identifier, set as a parameter, and gives it out one bit at a time through a serial shift register. A load strobe copies the whole identifier into the register in one clock. A step enable then moves the register contents one place toward the serial output on each clock, and brings a serial input bit in at the low end. When neither control is active, the register keeps its value.

The serial output always shows the most significant register bit. After a load it therefore reads 1, because the identifier always starts with 1 followed by 0. A consumer reads the full identifier, most significant bit first, with one load followed by 56 steps. If the register is kept stepping, the serial input bits appear on the output after 57 steps, so several such registers can be chained.

Top module: `serial_id_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the register holds all zeros, so `ser_o` reads 0 and stays 0 under stepping with `ser_i` at 0.
- R2: When `load_i` is high at a rising clock edge, all 57 bits of `ID_VALUE` are copied into the register. Stepping afterwards gives bit 56 down to bit 0 on `ser_o`, one bit per step.
- R3: The loaded word always has bit 56 = 1 and bit 55 = 0. So `ser_o` is 1 in the cycle after a load and 0 after one further step.
- R4: If `load_i` and `step_i` are both high on the same edge, the load takes place and the step is ignored.
- R5: When `step_i` is high and `load_i` is low at a rising edge, each bit moves from index k to index k+1, bit 56 is dropped, and `ser_i` enters bit 0.
- R6: When `load_i` and `step_i` are both low at an edge, the register and `ser_o` keep their values.
- R7: `ser_o` always equals register bit 56. After a step, it shows the bit that was at index 55 before that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the register |
| load_i | input | 1 | Parallel load of the identifier; has priority over step |
| step_i | input | 1 | Moves the register one place toward the output |
| ser_i | input | 1 | Serial bit taken in at bit 0 on a step |
| ser_o | output | 1 | Serial output, register bit 56 |

## Verification
Load and step can both be requested on the same edge, and the load must win. The bench raises both controls together in a directed case, after the register has been partly stepped out. It also raises them together often in the random phase. The result is judged by `ser_o` reading 1 afterwards, and by a full readout that must match the identifier bit for bit, with none of the stepped-in data left over.

// File: rtl/serial_id_pkg.sv
package serial_id_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } id_op_e;

endpackage

// File: rtl/serial_id_op_decode.sv
module serial_id_op_decode
    import serial_id_pkg::*;
(
    input  logic   load_i,
    input  logic   step_i,
    output id_op_e op_o
);

    // Load wins over step when both are requested.
    always_comb begin
        if (load_i) begin
            op_o = OP_LOAD;
        end else if (step_i) begin
            op_o = OP_SHIFT;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/serial_id_reg.sv
module serial_id_reg
    import serial_id_pkg::*;
#(
    parameter int unsigned     WIDTH    = 57,
    parameter logic [WIDTH-1:0] ID_VALUE = 57'h1_2A5C_3E91_7B24_D6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic step_i,
    input  logic ser_i,
    output logic ser_o
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } state_t;

    state_t state_d, state_q;
    id_op_e op;

    serial_id_op_decode i_decode (
        .load_i (load_i),
        .step_i (step_i),
        .op_o   (op)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD:  state_d.sr = ID_VALUE;
            OP_SHIFT: state_d.sr = {state_q.sr[MSB-1:0], ser_i};
            default:  state_d.sr = state_q.sr;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ser_o = state_q.sr[MSB];

    // Checks on the register behaviour
    assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (state_q.sr == ID_VALUE));

    // Also fires when an overridden ID_VALUE lacks the 1,0 top bits.
    assert_top_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (ser_o == 1'b1 && state_q.sr[MSB-1] == 1'b0));

    assert_load_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && step_i) |=> (state_q.sr == ID_VALUE));

    assert_shift_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i) |=> (state_q.sr == {$past(state_q.sr[MSB-1:0]), $past(ser_i)}));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> ($stable(state_q.sr) && $stable(ser_o)));

    assert_tap_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i) |=> (ser_o == $past(state_q.sr[MSB-1])));

endmodule

// File: tb/test_serial_id_reg.sv
module test_serial_id_reg;

    localparam int unsigned W = 57;
    localparam logic [W-1:0] ID = 57'h1_2A5C_3E91_7B24_D6;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic load_i = 1'b0;
    logic step_i = 1'b0;
    logic ser_i = 1'b0;
    logic ser_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;

    always #4 clk_i = ~clk_i;

    serial_id_reg #(.WIDTH(W), .ID_VALUE(ID)) i_serial_id_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_i),
        .step_i (step_i),
        .ser_i  (ser_i),
        .ser_o  (ser_o)
    );

    function automatic logic [W-1:0] next_model(input logic [W-1:0] q,
                                                input logic l, input logic s, input logic d);
        if (l) return ID;
        if (s) return {q[W-2:0], d};
        return q;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ser_o actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, let the rising edge act, then sample at the next falling edge.
    task automatic cycle(input logic l, input logic s, input logic d, input string req);
        load_i = l; step_i = s; ser_i = d;
        @(posedge clk_i);
        model = next_model(model, l, s, d);
        @(negedge clk_i);
        check(ser_o, model[W-1], req);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk_i);
        check(ser_o, 1'b0, "R1 in reset");
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(ser_o, 1'b0, "R1 after reset");
        for (int i = 0; i < W; i++) cycle(1'b0, 1'b1, 1'b0, "R1 zero content");

        // Full readout after a load
        cycle(1'b1, 1'b0, 1'b0, "R3 top bit after load");
        cycle(1'b0, 1'b1, 1'b1, "R3 second bit is zero");
        for (int i = 0; i < W - 2; i++) cycle(1'b0, 1'b1, 1'b1, "R2 readout");
        check(ser_o, ID[0], "R2 last identifier bit");
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 1'b1, "R5 input reaches output");

        // Hold
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, 1'b0, "R6 hold");

        // Load and step together, after partial stepping
        cycle(1'b1, 1'b0, 1'b0, "R2 reload");
        for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, 1'b1, "R7 tap");
        cycle(1'b1, 1'b1, 1'b1, "R4 load wins");
        for (int i = 0; i < W - 1; i++) cycle(1'b0, 1'b1, 1'b0, "R4 readout after collision");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            logic l = (r < 6);
            logic s = (r >= 3) && (r < 80);
            cycle(l, s, 1'($urandom), "R5 R6 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule